// File: doc/BRIEF.md
# Carry-Save Merge Adder with Split Lookahead Pipeline

This block turns a redundant carry-save pair (a sum vector and a carry vector) into one ordinary two's complement word. It sits directly after the final tap of a multiplierless transposed-form filter. It takes one pair per clock whenever the input valid is high, and it returns the merged word a fixed number of edges later with a matching valid.

The block places the carry vector one bit to the left of the sum vector, so the carry out of each column moves into the next column. The carry leaving the top bit is dropped, which makes the result the sum modulo 2^WIDTH. The lookahead network is a parallel prefix tree of generate/propagate combining cells. It is split at bit position CUT into a low segment and a high segment, with a register between the two. The carry leaving the low segment is held in that register, and in the next cycle it drives the carry input of the high segment. A register on the inputs isolates the block from the filter tap that feeds it, and the output is registered.

The reset is synchronous and active high. There is no backpressure: one operand pair can be accepted every cycle.

Top module: `csmerge_top`

## Requirements
- R1: While reset is high, and on the first sample after it falls, out_vld is 0 and out_data is 0.
- R2: For each accepted pair, out_data equals (in_sum + 2*in_cry) mod 2^WIDTH. Bit i of in_cry carries weight 2^(i+1).
- R3: The low CUT bits of the result are produced by the first lookahead segment and registered at the stage boundary.
- R4: The carry out of bit CUT-1 is registered at the stage boundary and drives the carry input of the high segment.
- R5: The high WIDTH-CUT bits of the result are the high operand bits plus the registered carry from the cut.
- R6: A pair sampled at rising edge k appears on out_data with out_vld high just after edge k+2 (three register stages). out_vld follows in_vld with the same delay.
- R7: A cycle with in_vld low produces out_vld low three edges later and leaves out_data at its previous value.
- R8: Pairs offered on back-to-back cycles each produce their own result on consecutive cycles.
- R9: Bit WIDTH-1 of in_cry has no effect on out_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand pair valid |
| in_sum | input | WIDTH | Carry-save sum vector |
| in_cry | input | WIDTH | Carry-save carry vector (placed one bit left) |
| out_vld | output | 1 | Result valid |
| out_data | output | WIDTH | Merged result, modulo 2^WIDTH |

## Verification
The bench builds the block with the default WIDTH=16 and CUT=9. With these values the low segment is nine bits wide and the high segment seven, so both segments have trees of different depth, and a carry created at bit 8 has to cross the pipeline register. Patterns such as 0x01FE plus an aligned carry, all ones, and alternating bits are included for this reason. The 16-bit width also lets the bench compare every result against a plain modular sum, with the top carry bit set or clear.

// File: rtl/csmerge_pkg.sv
package csmerge_pkg;
  function automatic int unsigned prefix_levels(int unsigned w);
    int unsigned l;
    l = 0;
    while ((1 << l) < w) l++;
    return l;
  endfunction
endpackage

// File: rtl/csmerge_black.sv
module csmerge_black (
  input  logic g_hi,
  input  logic p_hi,
  input  logic g_lo,
  input  logic p_lo,
  output logic g_out,
  output logic p_out
);
  assign g_out = g_hi | (p_hi & g_lo);
  assign p_out = p_hi & p_lo;
endmodule

// File: rtl/csmerge_prefix.sv
module csmerge_prefix
  import csmerge_pkg::*;
#(
  parameter int unsigned SEG_W = 8
) (
  input  logic [SEG_W-1:0] a,
  input  logic [SEG_W-1:0] b,
  input  logic             cin,
  output logic [SEG_W-1:0] sum,
  output logic             cout
);
  localparam int unsigned LV = prefix_levels(SEG_W);

  logic [LV:0][SEG_W-1:0] gk;
  logic [LV:0][SEG_W-1:0] pk;
  logic [SEG_W:0]         cy;

  assign gk[0] = a & b;
  assign pk[0] = a ^ b;

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    localparam int unsigned D = 1 << l;
    for (genvar i = 0; i < SEG_W; i++) begin : g_col
      if (i >= D) begin : g_cell
        csmerge_black u_blk (
          .g_hi (gk[l][i]),
          .p_hi (pk[l][i]),
          .g_lo (gk[l][i-D]),
          .p_lo (pk[l][i-D]),
          .g_out(gk[l+1][i]),
          .p_out(pk[l+1][i])
        );
      end else begin : g_pass
        assign gk[l+1][i] = gk[l][i];
        assign pk[l+1][i] = pk[l][i];
      end
    end
  end

  assign cy[0] = cin;
  for (genvar i = 0; i < SEG_W; i++) begin : g_carry
    assign cy[i+1] = gk[LV][i] | (pk[LV][i] & cin);
    assign sum[i]  = pk[0][i] ^ cy[i];
  end
  assign cout = cy[SEG_W];
endmodule

// File: rtl/csmerge_top.sv
module csmerge_top #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned CUT   = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [WIDTH-1:0] in_sum,
  input  logic [WIDTH-1:0] in_cry,
  output logic             out_vld,
  output logic [WIDTH-1:0] out_data
);
  localparam int unsigned HI = WIDTH - CUT;

  // input isolation register
  logic             s0_vld;
  logic [WIDTH-1:0] s0_a;
  logic [WIDTH-1:0] s0_b;
  logic             unused_cry_msb;
  assign unused_cry_msb = in_cry[WIDTH-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      s0_vld <= 1'b0;
      s0_a   <= '0;
      s0_b   <= '0;
    end else begin
      s0_vld <= in_vld;
      if (in_vld) begin
        s0_a <= in_sum;
        s0_b <= {in_cry[WIDTH-2:0], 1'b0};
      end
    end
  end

  // stage one: low segment
  logic [CUT-1:0] lo_sum;
  logic           lo_cout;
  csmerge_prefix #(.SEG_W(CUT)) u_lo (
    .a   (s0_a[CUT-1:0]),
    .b   (s0_b[CUT-1:0]),
    .cin (1'b0),
    .sum (lo_sum),
    .cout(lo_cout)
  );

  logic           s1_vld;
  logic [CUT-1:0] s1_lo;
  logic           s1_cy;
  logic [HI-1:0]  s1_ahi;
  logic [HI-1:0]  s1_bhi;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_lo  <= '0;
      s1_cy  <= 1'b0;
      s1_ahi <= '0;
      s1_bhi <= '0;
    end else begin
      s1_vld <= s0_vld;
      if (s0_vld) begin
        s1_lo  <= lo_sum;
        s1_cy  <= lo_cout;
        s1_ahi <= s0_a[WIDTH-1:CUT];
        s1_bhi <= s0_b[WIDTH-1:CUT];
      end
    end
  end

  // stage two: high segment fed by the latched cut carry
  logic [HI-1:0] hi_sum;
  logic          hi_cout;
  csmerge_prefix #(.SEG_W(HI)) u_hi (
    .a   (s1_ahi),
    .b   (s1_bhi),
    .cin (s1_cy),
    .sum (hi_sum),
    .cout(hi_cout)
  );
  logic unused_hi_cout;
  assign unused_hi_cout = hi_cout;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= s1_vld;
      if (s1_vld) out_data <= {hi_sum, s1_lo};
    end
  end

  // reference arithmetic for the checks, separate from the prefix trees
  logic [CUT:0]  chk_lo;
  logic [HI-1:0] chk_hi;
  assign chk_lo = {1'b0, s0_a[CUT-1:0]} + {1'b0, s0_b[CUT-1:0]};
  assign chk_hi = s1_ahi + s1_bhi + HI'(s1_cy);

  assert_lo_sum_R3: assert property (@(posedge clk) disable iff (rst)
    s0_vld |=> s1_lo == $past(chk_lo[CUT-1:0]));

  assert_cut_carry_R4: assert property (@(posedge clk) disable iff (rst)
    s0_vld |=> s1_cy == $past(chk_lo[CUT]));

  assert_hi_sum_R5: assert property (@(posedge clk) disable iff (rst)
    s1_vld |=> out_data[WIDTH-1:CUT] == $past(chk_hi));

  assert_vld_step_R6: assert property (@(posedge clk) disable iff (rst)
    s1_vld |=> out_vld);

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !s1_vld |=> !out_vld && $stable(out_data));
endmodule

// File: tb/csmerge_top_tb_top.sv
module csmerge_top_tb_top;
  localparam int unsigned W = 16;
  localparam int NV = 12;
  // each entry: {valid, sum, carry}
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 16'h0000, 16'h0000},
    {1'b1, 16'h01FE, 16'h0001},  // carry crosses the cut (R4)
    {1'b1, 16'hFFFF, 16'h7FFF},  // all ones
    {1'b1, 16'hAAAA, 16'h5555},  // alternating
    {1'b1, 16'h5555, 16'h2AAA},
    {1'b1, 16'h1234, 16'h8000},  // carry msb ignored (R9)
    {1'b0, 16'hDEAD, 16'hBEEF},  // idle (R7)
    {1'b1, 16'h00FF, 16'h0080},
    {1'b1, 16'hFE00, 16'h0100},  // high segment only (R5)
    {1'b0, 16'h1111, 16'h2222},
    {1'b1, 16'h7FFF, 16'h0000},
    {1'b1, 16'hFFFF, 16'hFFFF}
  };

  logic clk = 1'b0;
  logic rst;
  logic in_vld;
  logic [W-1:0] in_sum, in_cry;
  logic out_vld;
  logic [W-1:0] out_data;

  always #2.5 clk = ~clk;

  csmerge_top #(.WIDTH(W), .CUT(9)) dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_sum(in_sum),
    .in_cry(in_cry), .out_vld(out_vld), .out_data(out_data)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic         pv [3];
  logic [W-1:0] pe [3];
  logic [W-1:0] last_exp;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [W-1:0] s, input logic [W-1:0] c);
    @(negedge clk);
    chk("R6", {15'd0, out_vld}, {15'd0, pv[2]});
    if (pv[2]) begin
      chk("R2", out_data, pe[2]);
      last_exp = pe[2];
    end else begin
      chk("R7", out_data, last_exp);
    end
    pv[2] = pv[1]; pe[2] = pe[1];
    pv[1] = pv[0]; pe[1] = pe[0];
    pv[0] = v;     pe[0] = s + {c[W-2:0], 1'b0};
    in_vld = v; in_sum = s; in_cry = c;
  endtask

  initial begin
    rst = 1'b1; in_vld = 1'b0; in_sum = '0; in_cry = '0;
    for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; pe[i] = '0; end
    last_exp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", out_data, 16'h0000);
    chk("R1", {15'd0, out_vld}, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {15'd0, out_vld}, 16'h0000);
    // table walk, back-to-back (R8)
    for (int i = 0; i < NV; i++) step(VEC[i][32], VEC[i][31:16], VEC[i][15:0]);
    // R9: same sum, only carry msb differs
    step(1'b1, 16'h0F0F, 16'h0101);
    step(1'b1, 16'h0F0F, 16'h8101);
    // pseudo-random stream with gaps
    begin
      logic [31:0] lf = 32'hACE1_1234;
      for (int i = 0; i < 200; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        step(lf[3:0] != 4'h0, lf[31:16], lf[15:0] ^ lf[27:12]);
      end
    end
    for (int i = 0; i < 4; i++) step(1'b0, 16'h0, 16'h0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R6 act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule